// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 memory interface. It brings the device from power-up to a usable state. After its own reset it holds the memory reset pin low and then releases it. It keeps clock enable low through a settling wait and precedes the clock-enable rise with idle (NOP) commands. It then waits the exit-reset interval and writes the four mode registers in the order the device requires. Last, it issues a long ZQ calibration and waits for it to finish. When that wait expires, it raises a sticky `init_done` flag. From that point it drives NOP until later logic takes over the command bus.

Every interval is a parameter counted in controller clock cycles, worked out from the clock frequency at integration. The mode-register opcodes are also parameters. The sequencer forces the two bits that the power-up order depends on: DLL enable in MR1 and DLL reset in MR0. The memory command is the four active-low lines {`mem_sel_n`, `mem_row_n`, `mem_col_n`, `mem_wr_n`}. `mem_sel_n` high is a deselect, which masks any command.

Top module: `ddr3_init_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are: `mem_rst_n`=0, `mem_clk_en`=0, command lines 1111 (deselect), bank 0, address 0, `init_done`=0. This holds whatever phase the sequence was in.
- R2: After `rst_n` is released, `mem_rst_n` stays low for exactly T_RST cycles, counting the cycle of release, and then stays high.
- R3: After `mem_rst_n` rises, `mem_clk_en` stays low for T_CKEW + T_STAB cycles. The command is deselect (1111) for the first T_CKEW cycles and NOP (0111) for the last T_STAB cycles.
- R4: `mem_term_en` is 0 in every cycle of the sequence.
- R5: Once `mem_clk_en` rises it stays high. The first T_XPR cycles with it high carry NOP.
- R6: Exactly four mode-register writes follow, each a single cycle with command 0000. The bank field selects the register, in the order 2, 3, 1, 0, and the address carries that register's opcode.
- R7: The MR1 write carries MR1_OP with address bit 0 cleared (DLL enabled). The MR0 write carries MR0_OP with address bit 8 set (DLL reset).
- R8: Consecutive mode-register writes are T_MRD cycles apart, with NOP in the cycles between them.
- R9: T_MOD cycles after the last mode-register write, one ZQ long calibration is issued: command 0110, address with only bit 10 set, bank 0.
- R10: `init_done` rises exactly T_ZQINIT cycles after the ZQ calibration cycle, with NOP in the cycles between. It then stays high with NOP on the bus until the next reset.
- R11: A reset applied part-way through the sequence restarts it from the start of the memory-reset-low phase, with the full R2 to R10 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset; restarts the sequence |
| mem_rst_n | output | 1 | Active-low reset to the memory device |
| mem_clk_en | output | 1 | Clock enable to the memory device |
| mem_term_en | output | 1 | On-die termination enable, held inactive |
| mem_sel_n | output | 1 | Active-low chip select (command bit 3) |
| mem_row_n | output | 1 | Active-low row strobe (command bit 2) |
| mem_col_n | output | 1 | Active-low column strobe (command bit 1) |
| mem_wr_n | output | 1 | Active-low write enable (command bit 0) |
| mem_bank | output | 3 | Bank address; selects the mode register on a write |
| mem_addr | output | ADDR_W | Address bus; opcode or ZQ long flag |
| init_done | output | 1 | Sticky flag: device initialized |

## Verification
The bench predicts the full per-cycle pin trace from the parameters and compares every cycle. An off-by-one in any wait moves an edge and shows up at once. Likewise, a load order that swaps MR2 and MR3 or MR1 and MR0 gives a wrong bank value, and an opcode without the forced DLL bits gives a wrong address. The bench aims at two corners: the hand-over between the deselect and NOP phases before clock enable, and the spacing after the last mode-register write, which uses T_MOD instead of T_MRD. A sequencer that got these wrong would raise clock enable without idle commands or issue ZQ too early. A reset in the middle of the mode-register writes checks that the sequence restarts from the reset-low phase. A design that kept its step index would restart at the wrong register.

// File: rtl/ddr3i_pkg.sv
// Shared types for the DDR3 init sequencer: sequence phases, the
// active-low command word and its code points.
// Assumes command bit order {select, row, column, write}.
package ddr3i_pkg;

    typedef enum logic [2:0] {
        PH_RESET,   // memory reset held low
        PH_HOLD,    // reset released, clock enable low, deselect
        PH_NOP,     // idle commands just before clock enable
        PH_XPR,     // clock enable high, exit-reset wait
        PH_MRS,     // one mode-register write plus its gap
        PH_ZQ,      // long calibration plus its wait
        PH_READY    // done
    } phase_t;

    typedef struct packed {
        logic sel_n;
        logic row_n;
        logic col_n;
        logic wr_n;
    } cmd_t;

    localparam cmd_t CMD_DESEL = cmd_t'(4'b1111);
    localparam cmd_t CMD_NOP   = cmd_t'(4'b0111);
    localparam cmd_t CMD_MRS   = cmd_t'(4'b0000);
    localparam cmd_t CMD_ZQCL  = cmd_t'(4'b0110);

    // Larger of two integers, for sizing the interval counter.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr3i_timer.sv
// Interval timer. A load starts an interval of load_val cycles. The
// expired flag is high in its last cycle and first is high in its first
// cycle. Reset starts an interval of RST_LEN cycles.
// Assumes every interval is at least one cycle long.
module ddr3i_timer #(
    parameter int CNT_W   = 16,
    parameter int RST_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired,
    output logic             first
);
    logic [CNT_W-1:0] remain;

    // Count down the remaining cycles of the current interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= CNT_W'(RST_LEN - 1);
            first  <= 1'b1;
        end else if (load) begin
            remain <= load_val - 1'b1;
            first  <= 1'b1;
        end else begin
            first <= 1'b0;
            if (remain != '0) remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

    // The counter never leaves an interval early: a nonzero count only falls by one.
    assert_timer_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && remain != '0) |=> (remain == $past(remain) - 1'b1));

endmodule

// File: rtl/ddr3i_fsm.sv
// Phase controller. It walks the power-up phases and picks the length of
// the next interval. It also keeps the mode-register step:
// 0..3 = MR2, MR3, MR1, MR0.
// Assumes the timer reports expiry in the last cycle of each interval.
module ddr3i_fsm
    import ddr3i_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int T_CKEW   = 8,
    parameter int T_STAB   = 5,
    parameter int T_XPR    = 8,
    parameter int T_MRD    = 4,
    parameter int T_MOD    = 12,
    parameter int T_ZQINIT = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expired,
    output phase_t           phase,
    output logic [1:0]       step,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    phase_t     phase_nxt;
    logic [1:0] step_nxt;

    // Choose the next phase, step and interval length when an interval ends.
    always_comb begin
        phase_nxt = phase;
        step_nxt  = step;
        load      = 1'b0;
        load_val  = '0;
        if (expired) begin
            unique case (phase)
                PH_RESET: begin
                    phase_nxt = PH_HOLD;
                    load      = 1'b1;
                    load_val  = CNT_W'(T_CKEW);
                end
                PH_HOLD: begin
                    phase_nxt = PH_NOP;
                    load      = 1'b1;
                    load_val  = CNT_W'(T_STAB);
                end
                PH_NOP: begin
                    phase_nxt = PH_XPR;
                    load      = 1'b1;
                    load_val  = CNT_W'(T_XPR);
                end
                PH_XPR: begin
                    phase_nxt = PH_MRS;
                    step_nxt  = 2'd0;
                    load      = 1'b1;
                    load_val  = CNT_W'(T_MRD);
                end
                PH_MRS: begin
                    load = 1'b1;
                    if (step == 2'd3) begin
                        phase_nxt = PH_ZQ;
                        load_val  = CNT_W'(T_ZQINIT);
                    end else begin
                        step_nxt = step + 2'd1;
                        load_val = (step == 2'd2) ? CNT_W'(T_MOD) : CNT_W'(T_MRD);
                    end
                end
                PH_ZQ:    phase_nxt = PH_READY;
                default:  phase_nxt = PH_READY;
            endcase
        end
    end

    // Hold the phase and step registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_RESET;
            step  <= 2'd0;
        end else begin
            phase <= phase_nxt;
            step  <= step_nxt;
        end
    end

    // Ready is terminal until reset.
    assert_ready_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_READY) |=> (phase == PH_READY));

    // Calibration is only entered after the last mode-register step.
    assert_zq_after_mr0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ZQ && $past(phase) == PH_MRS) |-> ($past(step) == 2'd3));

endmodule

// File: rtl/ddr3i_cmd_enc.sv
// Pin encoder. It maps the phase, the step and the interval's first-cycle
// flag onto the memory reset, clock enable, command, bank and address pins.
// Assumes ADDR_W of at least 11, so the DLL-reset and ZQ-long bits exist.
module ddr3i_cmd_enc
    import ddr3i_pkg::*;
#(
    parameter int          ADDR_W = 14,
    parameter logic [13:0] MR0_OP = 14'h0520,
    parameter logic [13:0] MR1_OP = 14'h0044,
    parameter logic [13:0] MR2_OP = 14'h0008,
    parameter logic [13:0] MR3_OP = 14'h0000
) (
    input  phase_t            phase,
    input  logic [1:0]        step,
    input  logic              first,
    output logic              rst_o,
    output logic              cke_o,
    output cmd_t              cmd_o,
    output logic [2:0]        ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);
    localparam int DLL_RST_BIT = 8;
    localparam int DLL_DIS_BIT = 0;
    localparam int ZQ_LONG_BIT = 10;

    logic [ADDR_W-1:0] mr_op;
    logic [2:0]        mr_sel;

    // Per-step register select and opcode, with the forced DLL bits.
    always_comb begin
        mr_op = '0;
        unique case (step)
            2'd0: begin mr_sel = 3'd2; mr_op = ADDR_W'(MR2_OP); end
            2'd1: begin mr_sel = 3'd3; mr_op = ADDR_W'(MR3_OP); end
            2'd2: begin
                mr_sel = 3'd1;
                mr_op  = ADDR_W'(MR1_OP);
                mr_op[DLL_DIS_BIT] = 1'b0;
            end
            default: begin
                mr_sel = 3'd0;
                mr_op  = ADDR_W'(MR0_OP);
                mr_op[DLL_RST_BIT] = 1'b1;
            end
        endcase
    end

    // Drive the pins for the current phase.
    always_comb begin
        rst_o  = 1'b1;
        cke_o  = 1'b1;
        cmd_o  = CMD_NOP;
        ba_o   = 3'd0;
        addr_o = '0;
        done_o = 1'b0;
        unique case (phase)
            PH_RESET: begin rst_o = 1'b0; cke_o = 1'b0; cmd_o = CMD_DESEL; end
            PH_HOLD:  begin cke_o = 1'b0; cmd_o = CMD_DESEL; end
            PH_NOP:   cke_o = 1'b0;
            PH_XPR:   cmd_o = CMD_NOP;
            PH_MRS: if (first) begin
                cmd_o  = CMD_MRS;
                ba_o   = mr_sel;
                addr_o = mr_op;
            end
            PH_ZQ: if (first) begin
                cmd_o = CMD_ZQCL;
                addr_o[ZQ_LONG_BIT] = 1'b1;
            end
            default:  done_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/ddr3_init_seq.sv
// DDR3 power-up initialization sequencer (top). It connects the timer, the
// phase controller and the pin encoder. All intervals are in controller
// clock cycles. Assumes T_MRD >= 2, every other interval >= 1, ADDR_W >= 11.
module ddr3_init_seq
    import ddr3i_pkg::*;
#(
    parameter int          ADDR_W   = 14,
    parameter int          T_RST    = 20000,
    parameter int          T_CKEW   = 50000,
    parameter int          T_STAB   = 5,
    parameter int          T_XPR    = 27,
    parameter int          T_MRD    = 4,
    parameter int          T_MOD    = 12,
    parameter int          T_ZQINIT = 512,
    parameter logic [13:0] MR0_OP   = 14'h0520,
    parameter logic [13:0] MR1_OP   = 14'h0044,
    parameter logic [13:0] MR2_OP   = 14'h0008,
    parameter logic [13:0] MR3_OP   = 14'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_rst_n,
    output logic              mem_clk_en,
    output logic              mem_term_en,
    output logic              mem_sel_n,
    output logic              mem_row_n,
    output logic              mem_col_n,
    output logic              mem_wr_n,
    output logic [2:0]        mem_bank,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              init_done
);
    localparam int T_MAX = imax(imax(imax(T_RST, T_CKEW), imax(T_STAB, T_XPR)),
                                imax(imax(T_MRD, T_MOD), T_ZQINIT));
    localparam int CNT_W = $clog2(T_MAX + 1);

    phase_t           phase;
    logic [1:0]       step;
    logic             load, expired, first;
    logic [CNT_W-1:0] load_val;
    cmd_t             cmd;

    ddr3i_timer #(.CNT_W(CNT_W), .RST_LEN(T_RST)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .expired(expired), .first(first)
    );

    ddr3i_fsm #(
        .CNT_W(CNT_W), .T_CKEW(T_CKEW), .T_STAB(T_STAB), .T_XPR(T_XPR),
        .T_MRD(T_MRD), .T_MOD(T_MOD), .T_ZQINIT(T_ZQINIT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .expired(expired), .phase(phase),
        .step(step), .load(load), .load_val(load_val)
    );

    ddr3i_cmd_enc #(
        .ADDR_W(ADDR_W), .MR0_OP(MR0_OP), .MR1_OP(MR1_OP),
        .MR2_OP(MR2_OP), .MR3_OP(MR3_OP)
    ) u_enc (
        .phase(phase), .step(step), .first(first), .rst_o(mem_rst_n),
        .cke_o(mem_clk_en), .cmd_o(cmd), .ba_o(mem_bank), .addr_o(mem_addr),
        .done_o(init_done)
    );

    assign mem_sel_n   = cmd.sel_n;
    assign mem_row_n   = cmd.row_n;
    assign mem_col_n   = cmd.col_n;
    assign mem_wr_n    = cmd.wr_n;
    assign mem_term_en = 1'b0;

    // Clock enable never rises while the memory is still in reset.
    assert_cke_after_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_clk_en |-> mem_rst_n);

    // Once clock enable is high it stays high.
    assert_cke_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_clk_en |=> mem_clk_en);

    // A real command (not NOP or deselect) only goes out with clock enable high.
    assert_cmd_needs_cke_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && !(mem_row_n && mem_col_n && mem_wr_n)) |-> mem_clk_en);

    // Mode-register writes are never back to back.
    assert_mrs_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && !mem_row_n && !mem_col_n && !mem_wr_n)
        |=> !(!mem_sel_n && !mem_row_n && !mem_col_n && !mem_wr_n));

    // Done is sticky until reset.
    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

endmodule

// File: tb/ddr3_init_seq_test.sv
// Scoreboard bench: a driver task queues the expected pin vector for every
// cycle, worked out from the parameters. A monitor pops and compares one
// vector per cycle, 2 ns after each rising edge.
module ddr3_init_seq_test;

    localparam int T_RST = 6, T_CKEW = 5, T_STAB = 3, T_XPR = 4;
    localparam int T_MRD = 4, T_MOD = 6, T_ZQINIT = 10;
    localparam logic [13:0] MR0 = 14'h0030, MR1 = 14'h0005;
    localparam logic [13:0] MR2 = 14'h0018, MR3 = 14'h0004;

    typedef struct {
        logic [24:0] vec;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rst_n, mem_clk_en, mem_term_en;
    logic        mem_sel_n, mem_row_n, mem_col_n, mem_wr_n, init_done;
    logic [2:0]  mem_bank;
    logic [13:0] mem_addr;

    int   n_chk = 0, n_fail = 0;
    logic mon_on = 1'b0;
    exp_t q[$];

    always #5 clk = ~clk;

    ddr3_init_seq #(
        .ADDR_W(14), .T_RST(T_RST), .T_CKEW(T_CKEW), .T_STAB(T_STAB),
        .T_XPR(T_XPR), .T_MRD(T_MRD), .T_MOD(T_MOD), .T_ZQINIT(T_ZQINIT),
        .MR0_OP(MR0), .MR1_OP(MR1), .MR2_OP(MR2), .MR3_OP(MR3)
    ) uut (.*);

    function automatic logic [24:0] actual();
        return {mem_rst_n, mem_clk_en, mem_term_en, mem_sel_n, mem_row_n,
                mem_col_n, mem_wr_n, mem_bank, mem_addr, init_done};
    endfunction

    function automatic logic [24:0] mk(logic r, logic c, logic [3:0] cmd,
                                       logic [2:0] ba, logic [13:0] a, logic d);
        return {r, c, 1'b0, cmd, ba, a, d};
    endfunction

    task automatic push(int n, logic [24:0] v, string tag);
        for (int i = 0; i < n; i++) q.push_back('{vec: v, tag: tag});
    endtask

    task automatic check(logic [24:0] act, logic [24:0] exp, string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: expected trace of one full sequence from reset release.
    task automatic queue_sequence();
        logic [13:0] ops [4];
        logic [2:0]  bas [4];
        ops[0] = MR2;  bas[0] = 3'd2;
        ops[1] = MR3;  bas[1] = 3'd3;
        ops[2] = MR1 & ~14'h0001; bas[2] = 3'd1;   // R7: DLL enable
        ops[3] = MR0 | 14'h0100;  bas[3] = 3'd0;   // R7: DLL reset
        push(T_RST,  mk(0, 0, 4'hF, 0, 0, 0), "R2 reset low");
        push(T_CKEW, mk(1, 0, 4'hF, 0, 0, 0), "R3 deselect");
        push(T_STAB, mk(1, 0, 4'h7, 0, 0, 0), "R3 nop before cke");
        push(T_XPR,  mk(1, 1, 4'h7, 0, 0, 0), "R5 xpr wait");
        for (int k = 0; k < 4; k++) begin
            push(1, mk(1, 1, 4'h0, bas[k], ops[k], 0),
                 (k >= 2) ? "R7 R6 mode write" : "R6 mode write");
            push(((k == 3) ? T_MOD : T_MRD) - 1, mk(1, 1, 4'h7, 0, 0, 0),
                 (k == 3) ? "R9 tmod gap" : "R8 tmrd gap");
        end
        push(1, mk(1, 1, 4'h6, 0, 14'h0400, 0), "R9 zq long");
        push(T_ZQINIT - 1, mk(1, 1, 4'h7, 0, 0, 0), "R10 zq wait");
        push(8, mk(1, 1, 4'h7, 0, 0, 1), "R10 done held");
    endtask

    // Monitor: compare one queued vector per cycle; ODT is checked on its own (R4).
    always @(posedge clk) begin
        #2;
        if (mon_on && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(actual(), e.vec, e.tag);
            check({24'd0, mem_term_en}, 25'd0, "R4 termination off");
        end
    end

    task automatic wait_drain();
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        #3;
        mon_on = 1'b0;
    endtask

    task automatic check_reset(string tag);
        @(posedge clk);
        #2;
        check(actual(), mk(0, 0, 4'hF, 0, 0, 0), tag);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        check_reset("R1 reset state");

        // Run 1: full sequence.
        queue_sequence();
        @(posedge clk);
        #1 rst_n = 1'b1; mon_on = 1'b1;
        wait_drain();

        // R1: reset while ready clears done.
        rst_n = 1'b0;
        check_reset("R1 reset from ready");

        // R11: abort in the middle of the mode writes, then a full rerun.
        @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (T_RST + T_CKEW + T_STAB + T_XPR + 5) @(posedge clk);
        #1 rst_n = 1'b0;
        check_reset("R11 abort to reset");
        queue_sequence();
        @(posedge clk);
        #1 rst_n = 1'b1; mon_on = 1'b1;
        wait_drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule